// File: doc/BRIEF.md
# 64-bit Single-Cycle Integer Execution Unit

This block is the integer execute stage of a 64-bit core. It holds no state, and every operation produces its result within the same cycle. The block has three units that are picked per operation:

- **Adder/subtractor.** It serves signed and unsigned arithmetic. It also forms memory effective addresses from a base register plus a sign-extended 16-bit offset.
- **Logic unit.** It performs the bitwise operations. It also carries plain register moves, which pass the first operand through with no shift.
- **Shifter.** It executes the doubleword and word shift instructions. It also positions store data onto the byte lanes of a 64-bit bus.

A small decoder turns the operation code into a packed set of strobes. The datapath uses those strobes to steer its units.

For a store, the adder produces the address. The low three address bits and a size code then select the lanes. The lane order is big-endian: address offset 0 is the most significant byte of the bus. If a size/offset pair is not naturally aligned, the block raises an address error and drives no lanes.

Top module: `intAlu`

## Requirements
- R1: ADD (code 0) and ADDU (code 1) give opA+opB, and SUB (code 2) and SUBU (code 3) give opA-opB, all modulo 2^64.
- R2: overflow is 1 only for ADD, SUB and ADDI (code 4) when the two's-complement result overflows. ADDU, SUBU, ADDIU (code 5) and every other code keep it 0.
- R3: effAddr always carries the adder sum. For ADDI, ADDIU, EADDR (code 17) and STORE (code 18), that sum is opA plus imm sign-extended from bit 15. EADDR also returns this sum on result.
- R4: AND (6), OR (7), XOR (8) and NOR (9) return the bitwise function of opA and opB.
- R5: MOVE (10) returns opA unchanged, whatever opB, imm and shAmt are.
- R6: SLL (11), SRL (12) and SRA (13) shift all 64 bits of opA by shAmt, which ranges over 0..63. SRA fills from bit 63.
- R7: SLLW (14), SRLW (15) and SRAW (16) shift opA[31:0] by shAmt[4:0]. They ignore shAmt[5] and opA[63:32], and the result is sign-extended from its bit 31. SRAW fills from opA[31].
- R8: For STORE, with offset k = effAddr[2:0] and size S = 1<<stSize bytes (codes 0..3 give 1, 2, 4 and 8), byteEn[i] enables result[8i+7:8i]. Offset k maps to lane 7-k. Byte j (least significant first) of opB is placed in lane 7-(k+S-1-j). Lanes that are not enabled read zero.
- R9: A STORE whose k is not a multiple of S sets addrErr to 1, and forces byteEn and result to 0.
- R10: Every code other than STORE keeps byteEn at 0 and addrErr at 0.
- R11: Unassigned codes 19..31 give result 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 5 | Operation select |
| opA | input | 64 | First operand / address base / shift source |
| opB | input | 64 | Second operand / store data |
| imm | input | 16 | Signed immediate or address offset |
| shAmt | input | 6 | Shift amount |
| stSize | input | 2 | Store size code: 1, 2, 4 or 8 bytes |
| result | output | 64 | Operation result or aligned store data |
| effAddr | output | 64 | Adder sum (effective address for stores) |
| byteEn | output | 8 | Store lane enables, bit i for bits 8i+7:8i |
| overflow | output | 1 | Signed arithmetic overflow |
| addrErr | output | 1 | Misaligned store |

## Verification
The bench builds the block with its default widths: a 64-bit datapath and a 16-bit immediate. These widths give eight byte lanes and four store sizes, so all 32 size/offset pairs are driven and compared against a lane-by-lane model. The 6-bit shift amount lets the bench reach the extreme counts 0 and 63. It also lets the bench show that bit 5 of the amount has no effect on word shifts. The sign edges of the 64-bit adder and of the 16-bit immediate are hit directly to trip and clear overflow.

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,
    OP_ADDIU = 5'd5,
    OP_AND   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_NOR   = 5'd9,
    OP_MOVE  = 5'd10,
    OP_SLL   = 5'd11,
    OP_SRL   = 5'd12,
    OP_SRA   = 5'd13,
    OP_SLLW  = 5'd14,
    OP_SRLW  = 5'd15,
    OP_SRAW  = 5'd16,
    OP_EADDR = 5'd17,
    OP_STORE = 5'd18
  } aluOpT;

  typedef enum logic [2:0] {
    RES_ZERO,
    RES_ADD,
    RES_LOGIC,
    RES_SHIFT,
    RES_STORE
  } resSelT;

  typedef enum logic [2:0] {
    LF_AND,
    LF_OR,
    LF_XOR,
    LF_NOR,
    LF_PASS
  } logicFnT;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    resSelT  resSel;
    logic    subOp;
    logic    immSel;
    logic    ovfChk;
    logicFnT logicFn;
    logic    shRight;
    logic    shArith;
    logic    shWord;
    logic    storeEn;
  } ctrlT;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  aluOpT op,
  output ctrlT  ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.resSel  = RES_ZERO;
    ctrl.logicFn = LF_PASS;
    case (op)
      OP_ADD:   begin ctrl.resSel = RES_ADD; ctrl.ovfChk = 1'b1; end
      OP_ADDU:  ctrl.resSel = RES_ADD;
      OP_SUB:   begin ctrl.resSel = RES_ADD; ctrl.subOp = 1'b1; ctrl.ovfChk = 1'b1; end
      OP_SUBU:  begin ctrl.resSel = RES_ADD; ctrl.subOp = 1'b1; end
      OP_ADDI:  begin ctrl.resSel = RES_ADD; ctrl.immSel = 1'b1; ctrl.ovfChk = 1'b1; end
      OP_ADDIU: begin ctrl.resSel = RES_ADD; ctrl.immSel = 1'b1; end
      OP_EADDR: begin ctrl.resSel = RES_ADD; ctrl.immSel = 1'b1; end
      OP_AND:   begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LF_AND; end
      OP_OR:    begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LF_OR; end
      OP_XOR:   begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LF_XOR; end
      OP_NOR:   begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LF_NOR; end
      OP_MOVE:  begin ctrl.resSel = RES_LOGIC; ctrl.logicFn = LF_PASS; end
      OP_SLL:   ctrl.resSel = RES_SHIFT;
      OP_SRL:   begin ctrl.resSel = RES_SHIFT; ctrl.shRight = 1'b1; end
      OP_SRA:   begin ctrl.resSel = RES_SHIFT; ctrl.shRight = 1'b1; ctrl.shArith = 1'b1; end
      OP_SLLW:  begin ctrl.resSel = RES_SHIFT; ctrl.shWord = 1'b1; end
      OP_SRLW:  begin ctrl.resSel = RES_SHIFT; ctrl.shWord = 1'b1; ctrl.shRight = 1'b1; end
      OP_SRAW:  begin
        ctrl.resSel  = RES_SHIFT;
        ctrl.shWord  = 1'b1;
        ctrl.shRight = 1'b1;
        ctrl.shArith = 1'b1;
      end
      OP_STORE: begin
        ctrl.resSel  = RES_STORE;
        ctrl.immSel  = 1'b1;
        ctrl.storeEn = 1'b1;
      end
      default:  ctrl.resSel = RES_ZERO;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int LANE_W = $clog2(LANES),
  localparam int SIZE_W = $clog2(LANE_W + 1)
) (
  input  ctrlT              ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [SIZE_W-1:0] stSize,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] effAddr,
  output logic [LANES-1:0]  byteEn,
  output logic              overflow,
  output logic              addrErr
);

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = LANE_W + 1;

  // Adder / subtractor, shared by arithmetic and address generation
  logic [DATA_W-1:0] immExt, addB, addBEff, sum;

  always_comb begin
    immExt   = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    addB     = ctrl.immSel ? immExt : opB;
    addBEff  = ctrl.subOp ? ~addB : addB;
    sum      = opA + addBEff + DATA_W'(ctrl.subOp);
    overflow = ctrl.ovfChk && (opA[DATA_W-1] == addBEff[DATA_W-1])
                           && (sum[DATA_W-1] != opA[DATA_W-1]);
  end

  assign effAddr = sum;

  // Logic unit, including zero-shift moves
  logic [DATA_W-1:0] logicOut;

  always_comb begin
    case (ctrl.logicFn)
      LF_AND:  logicOut = opA & opB;
      LF_OR:   logicOut = opA | opB;
      LF_XOR:  logicOut = opA ^ opB;
      LF_NOR:  logicOut = ~(opA | opB);
      default: logicOut = opA;
    endcase
  end

  // Store lane geometry
  logic [LANE_W-1:0] laneOff;
  logic [CNT_W-1:0]  sizeBytes, laneShift;
  logic [LANES-1:0]  lowLanes;
  logic              misaligned;

  always_comb begin
    laneOff    = sum[LANE_W-1:0];
    sizeBytes  = CNT_W'(1) << stSize;
    misaligned = (CNT_W'(laneOff) & (sizeBytes - CNT_W'(1))) != '0;
    laneShift  = CNT_W'(LANES) - CNT_W'(laneOff) - sizeBytes;
    lowLanes   = {LANES{1'b1}} >> (CNT_W'(LANES) - sizeBytes);
  end

  logic [DATA_W-1:0] lowDataMask;

  for (genvar gL = 0; gL < LANES; gL++) begin : gLaneMask
    assign lowDataMask[8*gL +: 8] = {8{lowLanes[gL]}};
  end

  // Shared shifter: shift instructions and store alignment
  logic [DATA_W-1:0]   shIn, shOut, shResult;
  logic [SH_W-1:0]     shCnt;
  logic                shFill, goRight;
  logic [2*DATA_W-1:0] shWide;

  always_comb begin
    goRight = 1'b0;
    shFill  = 1'b0;
    shIn    = opA;
    shCnt   = shAmt;
    if (ctrl.storeEn) begin
      shIn  = opB & lowDataMask;
      shCnt = SH_W'({laneShift, 3'b000});
    end else if (ctrl.shWord) begin
      shCnt   = {1'b0, shAmt[SH_W-2:0]};
      goRight = ctrl.shRight;
      shFill  = ctrl.shArith & opA[HALF_W-1];
      if (ctrl.shRight) begin
        shIn = {{HALF_W{shFill}}, opA[HALF_W-1:0]};
      end
    end else begin
      goRight = ctrl.shRight;
      shFill  = ctrl.shArith & opA[DATA_W-1];
    end
    shWide   = {{DATA_W{shFill}}, shIn} >> shCnt;
    shOut    = goRight ? shWide[DATA_W-1:0] : (shIn << shCnt);
    shResult = ctrl.shWord ? {{HALF_W{shOut[HALF_W-1]}}, shOut[HALF_W-1:0]}
                           : shOut;
  end

  // Result select and store outputs
  always_comb begin
    addrErr = ctrl.storeEn & misaligned;
    byteEn  = '0;
    if (ctrl.storeEn && !misaligned) begin
      byteEn = lowLanes << laneShift[LANE_W-1:0];
    end
    case (ctrl.resSel)
      RES_ADD:   result = sum;
      RES_LOGIC: result = logicOut;
      RES_SHIFT: result = shResult;
      RES_STORE: result = misaligned ? '0 : shOut;
      default:   result = '0;
    endcase
  end

endmodule

// File: rtl/intAlu.sv
module intAlu
  import aluPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int LANE_W = $clog2(LANES),
  localparam int SIZE_W = $clog2(LANE_W + 1)
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [SIZE_W-1:0] stSize,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] effAddr,
  output logic [LANES-1:0]  byteEn,
  output logic              overflow,
  output logic              addrErr
);

  ctrlT ctrl;

  aluCtrl u_ctrl (
    .op   (aluOpT'(opCode)),
    .ctrl (ctrl)
  );

  aluDatapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .imm      (imm),
    .shAmt    (shAmt),
    .stSize   (stSize),
    .result   (result),
    .effAddr  (effAddr),
    .byteEn   (byteEn),
    .overflow (overflow),
    .addrErr  (addrErr)
  );

endmodule

// File: rtl/intAluChecker.sv
module intAluChecker
  import aluPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int LANE_W = $clog2(LANES),
  localparam int SIZE_W = $clog2(LANE_W + 1)
) (
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] opA,
  input logic [SIZE_W-1:0] stSize,
  input logic [DATA_W-1:0] result,
  input logic [LANES-1:0]  byteEn,
  input logic              overflow,
  input logic              addrErr
);

  logic [DATA_W-1:0] laneBits;

  for (genvar gL = 0; gL < LANES; gL++) begin : gBits
    assign laneBits[gL*8 +: 8] = {8{byteEn[gL]}};
  end

  always_comb begin
    if (!$isunknown({opCode, opA, stSize, result, byteEn, overflow, addrErr})) begin
      p_ovf_signed_only_r2: assert (!overflow || opCode == OP_ADD ||
                                    opCode == OP_SUB || opCode == OP_ADDI)
        else $error("overflow raised for opcode %0d", opCode);
      p_move_passthru_r5: assert (opCode != OP_MOVE || result == opA)
        else $error("move altered its operand");
      p_lane_count_r8: assert (opCode != OP_STORE || addrErr ||
                               $countones(byteEn) == (32'd1 << stSize))
        else $error("store lane count wrong");
      p_unused_lanes_zero_r8: assert (opCode != OP_STORE || (result & ~laneBits) == '0)
        else $error("store data outside enabled lanes");
      p_err_no_lanes_r9: assert (!addrErr || (byteEn == '0 && result == '0))
        else $error("misaligned store drove lanes");
      p_nonstore_quiet_r10: assert (opCode == OP_STORE || (byteEn == '0 && !addrErr))
        else $error("lanes or error raised outside a store");
      p_unassigned_zero_r11: assert (opCode <= OP_STORE || (result == '0 && !overflow))
        else $error("unassigned opcode produced output");
    end
  end

endmodule

bind intAlu intAluChecker #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W)
) u_chk (
  .opCode   (opCode),
  .opA      (opA),
  .stSize   (stSize),
  .result   (result),
  .byteEn   (byteEn),
  .overflow (overflow),
  .addrErr  (addrErr)
);

// File: tb/intAlu_bench.sv
`timescale 1ns/1ps
module intAlu_bench;
  import aluPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  opCode;
  logic [63:0] opA, opB, result, effAddr;
  logic [15:0] imm;
  logic [5:0]  shAmt;
  logic [1:0]  stSize;
  logic [7:0]  byteEn;
  logic        overflow, addrErr;

  int nChecks = 0;
  int nFail   = 0;

  intAlu u_intAlu (
    .opCode   (opCode),
    .opA      (opA),
    .opB      (opB),
    .imm      (imm),
    .shAmt    (shAmt),
    .stSize   (stSize),
    .result   (result),
    .effAddr  (effAddr),
    .byteEn   (byteEn),
    .overflow (overflow),
    .addrErr  (addrErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] im, input logic [5:0] sh, input logic [1:0] sz);
    @(posedge clk);
    #1;
    opCode = op; opA = a; opB = b; imm = im; shAmt = sh; stSize = sz;
    @(negedge clk);
  endtask

  task automatic tIdle();
    drive(5'(OP_ADD), 64'd0, 64'd0, 16'd0, 6'd0, 2'd0);
    chk("R1 idle result", result, 64'd0);
    chk("R2 idle overflow", 64'(overflow), 64'd0);
    chk("R10 idle byteEn", 64'(byteEn), 64'd0);
    chk("R10 idle addrErr", 64'(addrErr), 64'd0);
  endtask

  task automatic tAddSub();
    drive(5'(OP_ADD), 64'd5, 64'd7, 16'd0, 6'd0, 2'd0);
    chk("R1 add", result, 64'd12);
    drive(5'(OP_ADD), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 6'd0, 2'd0);
    chk("R1 add wrap", result, 64'h8000_0000_0000_0000);
    chk("R2 add overflow", 64'(overflow), 64'd1);
    drive(5'(OP_ADDU), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 6'd0, 2'd0);
    chk("R2 addu no flag", 64'(overflow), 64'd0);
    drive(5'(OP_ADD), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, 6'd0, 2'd0);
    chk("R1 add negatives", result, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R2 add negatives no flag", 64'(overflow), 64'd0);
    drive(5'(OP_SUB), 64'h8000_0000_0000_0000, 64'd1, 16'd0, 6'd0, 2'd0);
    chk("R1 sub", result, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R2 sub overflow", 64'(overflow), 64'd1);
    drive(5'(OP_SUB), 64'd0, 64'h8000_0000_0000_0000, 16'd0, 6'd0, 2'd0);
    chk("R2 sub min overflow", 64'(overflow), 64'd1);
    drive(5'(OP_SUBU), 64'd3, 64'd5, 16'd0, 6'd0, 2'd0);
    chk("R1 subu", result, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R2 subu no flag", 64'(overflow), 64'd0);
  endtask

  task automatic tImm();
    drive(5'(OP_ADDI), 64'h1000, 64'hDEAD, 16'hFFFC, 6'd0, 2'd0);
    chk("R3 addi negative imm", result, 64'h0FFC);
    chk("R3 effAddr addi", effAddr, 64'h0FFC);
    drive(5'(OP_ADDI), 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'd1, 6'd0, 2'd0);
    chk("R2 addi overflow", 64'(overflow), 64'd1);
    drive(5'(OP_ADDIU), 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'd1, 6'd0, 2'd0);
    chk("R2 addiu no flag", 64'(overflow), 64'd0);
    drive(5'(OP_EADDR), 64'h2000, 64'h5555, 16'h7FFF, 6'd0, 2'd0);
    chk("R3 eaddr result", result, 64'h9FFF);
    chk("R3 eaddr effAddr", effAddr, 64'h9FFF);
    chk("R2 eaddr no flag", 64'(overflow), 64'd0);
    chk("R10 eaddr no lanes", 64'(byteEn), 64'd0);
    drive(5'(OP_STORE), 64'h1003, 64'hAABB, 16'hFFFF, 6'd0, 2'd1);
    chk("R3 store effAddr", effAddr, 64'h1002);
    chk("R8 store half lanes", 64'(byteEn), 64'h30);
    chk("R8 store half data", result, 64'h0000_AABB_0000_0000);
  endtask

  task automatic tLogic();
    logic [63:0] a = 64'hF0F0_1234_FFFF_0000;
    logic [63:0] b = 64'h0FF0_4321_00FF_FF00;
    drive(5'(OP_AND), a, b, 16'd0, 6'd0, 2'd0);
    chk("R4 and", result, a & b);
    drive(5'(OP_OR), a, b, 16'd0, 6'd0, 2'd0);
    chk("R4 or", result, a | b);
    drive(5'(OP_XOR), a, b, 16'd0, 6'd0, 2'd0);
    chk("R4 xor", result, a ^ b);
    drive(5'(OP_NOR), a, b, 16'd0, 6'd0, 2'd0);
    chk("R4 nor", result, ~(a | b));
    chk("R10 logic no err", 64'(addrErr), 64'd0);
  endtask

  task automatic tMove();
    drive(5'(OP_MOVE), 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8000, 6'd37, 2'd3);
    chk("R5 move", result, 64'h0123_4567_89AB_CDEF);
    chk("R5 move no flag", 64'(overflow), 64'd0);
  endtask

  task automatic tShift64();
    drive(5'(OP_SLL), 64'd1, 64'd0, 16'd0, 6'd63, 2'd0);
    chk("R6 sll 63", result, 64'h8000_0000_0000_0000);
    drive(5'(OP_SLL), 64'hABCD, 64'd0, 16'd0, 6'd0, 2'd0);
    chk("R6 sll 0", result, 64'hABCD);
    drive(5'(OP_SRL), 64'h8000_0000_0000_0000, 64'd0, 16'd0, 6'd63, 2'd0);
    chk("R6 srl 63", result, 64'd1);
    drive(5'(OP_SRA), 64'h8000_0000_0000_0000, 64'd0, 16'd0, 6'd4, 2'd0);
    chk("R6 sra fill", result, 64'hF800_0000_0000_0000);
    drive(5'(OP_SRA), 64'h4000_0000_0000_0000, 64'd0, 16'd0, 6'd62, 2'd0);
    chk("R6 sra positive", result, 64'd1);
  endtask

  task automatic tShiftWord();
    drive(5'(OP_SLLW), 64'd1, 64'd0, 16'd0, 6'd31, 2'd0);
    chk("R7 sllw sign", result, 64'hFFFF_FFFF_8000_0000);
    drive(5'(OP_SLLW), 64'd1, 64'd0, 16'd0, 6'd63, 2'd0);
    chk("R7 sllw amt bit5 ignored", result, 64'hFFFF_FFFF_8000_0000);
    drive(5'(OP_SLLW), 64'hDEAD_BEEF_0000_0010, 64'd0, 16'd0, 6'd1, 2'd0);
    chk("R7 sllw upper ignored", result, 64'h20);
    drive(5'(OP_SRLW), 64'hFFFF_FFFF_8000_0000, 64'd0, 16'd0, 6'd4, 2'd0);
    chk("R7 srlw", result, 64'h0800_0000);
    drive(5'(OP_SRLW), 64'h0000_0000_8000_0000, 64'd0, 16'd0, 6'd0, 2'd0);
    chk("R7 srlw 0 sext", result, 64'hFFFF_FFFF_8000_0000);
    drive(5'(OP_SRAW), 64'h0000_0000_8000_0000, 64'd0, 16'd0, 6'd4, 2'd0);
    chk("R7 sraw fill", result, 64'hFFFF_FFFF_F800_0000);
    drive(5'(OP_SRAW), 64'hFFFF_FFFF_7000_0000, 64'd0, 16'd0, 6'd36, 2'd0);
    chk("R7 sraw positive", result, 64'h0700_0000);
  endtask

  task automatic tStoreAll();
    logic [63:0] data = 64'h1122_3344_5566_7788;
    for (int sz = 0; sz < 4; sz++) begin
      for (int k = 0; k < 8; k++) begin
        int s = 1 << sz;
        logic [63:0] expRes = '0;
        logic [7:0]  expBe  = '0;
        logic        expErr = (k % s) != 0;
        if (!expErr) begin
          for (int j = 0; j < s; j++) begin
            int lane = 7 - (k + s - 1 - j);
            expRes[lane*8 +: 8] = data[j*8 +: 8];
            expBe[lane] = 1'b1;
          end
        end
        drive(5'(OP_STORE), 64'h4000, data, 16'(k), 6'd9, 2'(sz));
        chk(expErr ? "R9 misaligned data" : "R8 store data", result, expRes);
        chk(expErr ? "R9 misaligned lanes" : "R8 store lanes", 64'(byteEn), 64'(expBe));
        chk("R9 addrErr", 64'(addrErr), 64'(expErr));
      end
    end
  endtask

  task automatic tUnassigned();
    drive(5'd19, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd1, 6'd3, 2'd1);
    chk("R11 code 19 result", result, 64'd0);
    chk("R11 code 19 overflow", 64'(overflow), 64'd0);
    drive(5'd31, 64'hFFFF, 64'hFFFF, 16'd0, 6'd1, 2'd0);
    chk("R11 code 31 result", result, 64'd0);
    chk("R10 code 31 lanes", 64'(byteEn), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    opCode = '0; opA = '0; opB = '0; imm = '0; shAmt = '0; stSize = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    tIdle();
    tAddSub();
    tImm();
    tLogic();
    tMove();
    tShift64();
    tShiftWord();
    tStoreAll();
    tUnassigned();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule